// File: doc/BRIEF.md
# Global-Clock Emulated RAM Write Port

This block is a small RAM whose write port belongs to a slow design clock, rebuilt so that every register in it runs on one fast global clock. The design clock is treated as a plain data input. The block samples it, together with the write enable, address and data, on every global cycle. A write takes place only in a global cycle where the sampled design clock has just reached its active level. That write uses the enable, address and data captured one global cycle earlier, which is the value a real edge-triggered port would have latched just before its edge. Read ports are purely combinational. This makes a design with several clocks checkable in a single global time base.

A two-state machine tracks the previous design-clock sample. In state `EDG_HELD` the previous sample was at the active level. In state `EDG_ARMED` it was at the inactive level. The transition `HELD_TO_ARMED` is taken when the current sample is inactive. The transition `ARMED_TO_HELD` is taken when the current sample is active, and this transition is the write strobe. Reset enters `EDG_HELD`, so a clock that is already active after reset does not count as an edge.

The parameters set the depth, the data width and the clock polarity. A parameter that requests a registered read port stops elaboration with an error, because this emulation offers no such port.

Top module: `gclk_wrport`

## Requirements
- R1: A write commits only at the global edge that closes a cycle in which the design clock sample is at its active level and the sample of the previous global cycle was inactive. Two consecutive global cycles can never both commit.
- R2: After reset, the previous design-clock sample counts as active. A design clock that is active in the first global cycle after reset causes no write.
- R3: A committed write uses the enable, address and data presented in the global cycle before the edge cycle. Values presented in the edge cycle itself are not used by that write.
- R4: The enable is per bit. Enable bit i set writes data bit i. Enable bit i clear leaves stored bit i unchanged.
- R5: A design clock that holds its level, or that moves to its inactive level, leaves the memory contents unchanged whatever the enable, address and data.
- R6: `rd_data` is a combinational function of `rd_addr` and the stored contents. A committed write is visible on `rd_data` right after the global edge that commits it.
- R7: A write whose captured address is DEPTH or larger changes no location. A read from such an address returns zero.
- R8: When ACTIVE_HIGH is 0, the active level is low. A design clock falling from 1 to 0 is then the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the edge tracker and capture registers |
| wr_clk_smp | input | 1 | Design write clock, sampled as data |
| wr_en | input | DW | Per-bit write enable |
| wr_addr | input | AW | Write address, AW = clog2(DEPTH) |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Combinational read data |

## Verification
An enable, address and data pattern is presented in global cycle n-1. The design clock becomes active in cycle n. The new word can be read in cycle n+1, after the rising global edge that ends cycle n. The bench drives every input at a falling global edge and samples `rd_data` 1 ns later, in the same cycle. Its reference model updates at the rising edge that ends the cycle, using the inputs captured in the previous step. A cycle with no rising edge of the design clock therefore leaves every compared word as it was. A second instance with the opposite polarity receives the inverted design clock. It must track the same reference memory.

// File: rtl/gclk_wrport_pkg.sv
package gclk_wrport_pkg;

    // Level of the design clock seen on the previous global cycle
    typedef enum logic {
        EDG_HELD  = 1'b0,   // previous sample at the active level
        EDG_ARMED = 1'b1    // previous sample at the inactive level
    } edge_state_e;

    // Width of an address bus able to select DEPTH words
    function automatic int addr_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/gclk_wrport_edge.sv
module gclk_wrport_edge #(
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wclk_smp,
    output logic wr_fire
);
    import gclk_wrport_pkg::*;

    logic        lvl_act;
    edge_state_e st_q;
    edge_state_e st_d;

    generate
        if (ACTIVE_HIGH) begin : g_act_hi
            assign lvl_act = wclk_smp;
        end else begin : g_act_lo
            assign lvl_act = ~wclk_smp;
        end
    endgenerate

    // State register: reset assumes the clock was already active
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= EDG_HELD;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions HELD_TO_ARMED and ARMED_TO_HELD
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EDG_HELD:  if (!lvl_act) st_d = EDG_ARMED;
            EDG_ARMED: if (lvl_act)  st_d = EDG_HELD;
            default:   st_d = EDG_HELD;
        endcase
    end

    // Output: strobe on the ARMED_TO_HELD transition
    always_comb begin
        wr_fire = 1'b0;
        unique case (st_q)
            EDG_ARMED: wr_fire = lvl_act;
            default:   wr_fire = 1'b0;
        endcase
    end

endmodule

// File: rtl/gclk_wrport_capture.sv
module gclk_wrport_capture #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] en_in,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] en_q,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);

    // One global cycle of delay on every write field
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            en_q   <= en_in;
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end

endmodule

// File: rtl/gclk_wrport_store.sv
module gclk_wrport_store #(
    parameter int DEPTH = 12,
    parameter int AW    = 4,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          wr_fire,
    input  logic [DW-1:0] en_q,
    input  logic [AW-1:0] addr_q,
    input  logic [DW-1:0] data_q,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam logic [AW:0] DEPTH_W = DEPTH[AW:0];

    logic [DW-1:0] mem [DEPTH];
    logic          wr_in_range;
    logic          rd_in_range;

    assign wr_in_range = ({1'b0, addr_q}  < DEPTH_W);
    assign rd_in_range = ({1'b0, rd_addr} < DEPTH_W);

    // Storage has no clock of its own: the strobe alone qualifies it
    always_ff @(posedge clk) begin
        if (wr_fire && wr_in_range) begin
            for (int b = 0; b < DW; b++) begin
                if (en_q[b]) begin
                    mem[addr_q][b] <= data_q[b];
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_in_range) begin
            rd_data = mem[rd_addr];
        end
    end

endmodule

// File: rtl/gclk_wrport.sv
module gclk_wrport #(
    parameter int  DEPTH         = 12,
    parameter int  DW            = 8,
    parameter bit  ACTIVE_HIGH   = 1'b1,
    parameter bit  RD_REGISTERED = 1'b0,
    localparam int AW            = gclk_wrport_pkg::addr_bits(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_clk_smp,
    input  logic [DW-1:0] wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic          wr_fire;
    logic [DW-1:0] en_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    generate
        if (RD_REGISTERED) begin : g_bad_cfg
            $error("gclk_wrport: a registered read port cannot be emulated");
        end
    endgenerate

    gclk_wrport_edge #(
        .ACTIVE_HIGH (ACTIVE_HIGH)
    ) edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wclk_smp (wr_clk_smp),
        .wr_fire  (wr_fire)
    );

    gclk_wrport_capture #(
        .AW (AW),
        .DW (DW)
    ) cap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_in   (wr_en),
        .addr_in (wr_addr),
        .data_in (wr_data),
        .en_q    (en_q),
        .addr_q  (addr_q),
        .data_q  (data_q)
    );

    gclk_wrport_store #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .DW    (DW)
    ) store_i (
        .clk     (clk),
        .wr_fire (wr_fire),
        .en_q    (en_q),
        .addr_q  (addr_q),
        .data_q  (data_q),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/gclk_wrport_chk.sv
module gclk_wrport_chk #(
    parameter int DEPTH       = 12,
    parameter int DW          = 8,
    parameter bit ACTIVE_HIGH = 1'b1,
    parameter int AW          = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_clk_smp,
    input logic [DW-1:0] wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic [AW-1:0] rd_addr,
    input logic [DW-1:0] rd_data,
    input logic          wr_fire,
    input logic [DW-1:0] en_q,
    input logic [AW-1:0] addr_q,
    input logic [DW-1:0] data_q
);
    localparam logic [AW:0] DEPTH_W = DEPTH[AW:0];

    logic act_now;
    logic hit;
    assign act_now = (wr_clk_smp == ACTIVE_HIGH);
    assign hit     = wr_fire && ({1'b0, addr_q} < DEPTH_W) && (addr_q == rd_addr);

    p_fire_on_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |-> act_now && ($past(wr_clk_smp) != ACTIVE_HIGH));

    p_no_back_to_back_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> !wr_fire);

    p_quiet_after_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !wr_fire);

    p_capture_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (en_q == $past(wr_en)) && (addr_q == $past(wr_addr))
                         && (data_q == $past(wr_data)));

    p_enabled_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !$stable(rd_addr) || (((rd_data ^ $past(data_q)) & $past(en_q)) == '0));

    p_masked_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !$stable(rd_addr) || (((rd_data ^ $past(rd_data)) & ~$past(en_q)) == '0));

    p_no_fire_no_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_fire) && $stable(rd_addr) |-> $stable(rd_data));

    p_oob_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rd_addr} >= DEPTH_W) |-> (rd_data == '0));

endmodule

bind gclk_wrport gclk_wrport_chk #(
    .DEPTH       (DEPTH),
    .DW          (DW),
    .ACTIVE_HIGH (ACTIVE_HIGH),
    .AW          (AW)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_clk_smp (wr_clk_smp),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .wr_fire    (wr_fire),
    .en_q       (en_q),
    .addr_q     (addr_q),
    .data_q     (data_q)
);

// File: tb/gclk_wrport_tb.sv
`timescale 1ns/1ps
module gclk_wrport_tb_top;
    localparam int DEPTH = 12;
    localparam int DW    = 8;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lvl = 1'b1;
    logic [DW-1:0] wen = '0;
    logic [AW-1:0] waddr = '0;
    logic [DW-1:0] wdata = '0;
    logic [AW-1:0] raddr = '0;
    logic [DW-1:0] rdata_hi;
    logic [DW-1:0] rdata_lo;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 1'b0;
    bit done   = 1'b0;

    // reference model state
    logic [DW-1:0] ref_mem [DEPTH];
    logic          m_lvl  = 1'b1;
    logic [DW-1:0] m_en   = '0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0;

    always #2.5 clk = ~clk;

    gclk_wrport #(.DEPTH(DEPTH), .DW(DW), .ACTIVE_HIGH(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_clk_smp(lvl), .wr_en(wen),
        .wr_addr(waddr), .wr_data(wdata), .rd_addr(raddr), .rd_data(rdata_hi));

    gclk_wrport #(.DEPTH(DEPTH), .DW(DW), .ACTIVE_HIGH(1'b0)) dut_lo_i (
        .clk(clk), .rst_n(rst_n), .wr_clk_smp(~lvl), .wr_en(wen),
        .wr_addr(waddr), .wr_data(wdata), .rd_addr(raddr), .rd_data(rdata_lo));

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        if (int'(a) < DEPTH) return ref_mem[a];
        return '0;
    endfunction

    // model commits on a true rising design-clock edge at the global edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lvl = 1'b1;
            m_en  = '0;
        end else begin
            if (lvl && !m_lvl && int'(m_addr) < DEPTH)
                ref_mem[m_addr] = (ref_mem[m_addr] & ~m_en) | (m_data & m_en);
            m_lvl  = lvl;
            m_en   = wen;
            m_addr = waddr;
            m_data = wdata;
        end
    end

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // one global cycle: drive at falling edge, sample 1 ns later
    task automatic step(input logic l, input logic [DW-1:0] e, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [AW-1:0] ra);
        @(negedge clk);
        lvl = l; wen = e; waddr = a; wdata = d; raddr = ra;
        #1;
        if (cmp_on) begin
            check("R6 read vs model", rdata_hi, exp_read(ra));
            check("R8 low-polarity read vs model", rdata_lo, exp_read(ra));
        end
    endtask

    task automatic read_chk(input string req, input logic [AW-1:0] ra, input logic [DW-1:0] exp);
        @(negedge clk);
        raddr = ra; wen = '0;
        #1;
        check(req, rdata_hi, exp);
        check({req, " low polarity R8"}, rdata_lo, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // fill every location with a known pattern
        for (int a = 0; a < DEPTH; a++) begin
            step(1'b0, '1, AW'(a), DW'(a * 17 + 3), '0);
            step(1'b1, '0, AW'(a), '0, '0);
        end
        step(1'b0, '0, '0, '0, '0);
        cmp_on = 1'b1;
        read_chk("R6 fill word 0", 4'd0, 8'h03);
        read_chk("R6 fill word 11", 4'd11, 8'hBe);

        // R2: reset with clock active, first cycle active is no edge
        @(negedge clk); rst_n = 1'b0; lvl = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, '1, 4'd3, 8'hAA, 4'd3);
        step(1'b1, '1, 4'd3, 8'hAA, 4'd3);
        read_chk("R2 active clock after reset", 4'd3, 8'h36);

        // R3: edge-cycle values are not used
        step(1'b0, '1, 4'd5, 8'h11, 4'd5);
        step(1'b1, '1, 4'd6, 8'h22, 4'd5);
        read_chk("R3 uses previous-cycle fields", 4'd5, 8'h11);
        read_chk("R3 edge-cycle address untouched", 4'd6, 8'h69);
        read_chk("R1 commit only on rise", 4'd6, 8'h69);

        // R4: partial write
        step(1'b0, 8'h0F, 4'd7, 8'hFF, 4'd7);
        step(1'b1, '0, 4'd7, '0, 4'd7);
        read_chk("R4 low nibble only", 4'd7, 8'h7F);

        // R5: held and falling clock with full enables
        step(1'b1, '1, 4'd8, 8'h55, 4'd8);
        step(1'b0, '1, 4'd8, 8'h55, 4'd8);
        read_chk("R5 hold and fall no write", 4'd8, 8'h8B);

        // R7: out-of-range write and read
        step(1'b0, '1, 4'd13, 8'h77, 4'd13);
        step(1'b1, '0, 4'd13, '0, 4'd13);
        read_chk("R7 out-of-range read zero", 4'd13, 8'h00);
        read_chk("R7 word 1 untouched", 4'd1, 8'h14);
        read_chk("R7 word 2 untouched", 4'd2, 8'h25);

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            step(1'($urandom_range(0, 1)), DW'($urandom), AW'($urandom_range(0, 15)),
                 DW'($urandom), AW'($urandom_range(0, 15)));
        end
        for (int a = 0; a < 16; a++) read_chk("R6 final sweep", AW'(a), exp_read(AW'(a)));

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule